// File: doc/BRIEF.md
# Inverted Page Table Lookup Engine

This engine turns a virtual page number into a physical frame number by searching an inverted page table. That table has one entry per physical frame. Each entry holds the page number and the address-space tag of the page now placed in that frame, plus a valid flag and a link to the next entry. The engine hashes the page number and adds a base register to it to find a slot in a hash anchor table. That slot points to the head of a chain of candidate entries. The engine then follows the chain one entry at a time. A hit returns the position of the matching entry as the frame number. An empty anchor or the end of the chain returns a page fault.

Both tables live in a single synchronous memory with one read port and a read latency of one cycle. Software fills and maintains the tables. A programmable limit caps how many entries one walk may examine. A damaged chain that loops back on itself therefore ends in a fault and cannot stall the engine. The address-space tag comes from a dedicated register input. It is captured with each request, so the same page number used by different processes resolves to different frames.

Top module: `ipt_lookup_engine`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `mem_rd_en` is 0.
- R2: The first memory read of a walk goes to `hat_base + h`. Here `h` is computed in two steps. First, the upper 10 bits of the 20-bit page number are XORed with the lower 10 bits. Then bits 9:8 of that result are XORed into bits 1:0, which gives an 8-bit index.
- R3: The anchor pointer sits in bits 7:0 of the anchor word, and the value 8'hFF means null. A null anchor gives a fault with no entry read.
- R4: An entry word holds the next pointer in bits 7:0, the page number in bits 27:8, the tag in bits 35:28 and the valid flag in bit 36. Entry `f` is read at address `ipt_base + f`. An entry hits when it is valid and both its page number and tag equal the request. The hit reports `resp_frame = f`.
- R5: Entries are examined in chain order. The first matching entry wins, even when a later entry would also match.
- R6: An entry whose page number matches but whose tag differs is not a hit. The walk continues past it.
- R7: An entry with the valid flag clear is never a hit. Its next pointer is still followed.
- R8: When the chain ends (next pointer 8'hFF) with no match, the response is a fault with `resp_limit` 0 and `resp_frame` 8'hFF.
- R9: A walk examines at most `max_chain` entries, and a value of 0 counts as 1. Suppose that many entries have been examined with no match and the next pointer is not null. The response is then a fault with `resp_limit` 1. A match on the last permitted entry is still a hit.
- R10: A walk that reads `k` entries raises `resp_valid` for exactly one cycle, `k+2` clock edges after the edge that accepted the request. `req_ready` stays low from the accepting edge until the response.
- R11: Every response has exactly one of `resp_hit` and `resp_fault` set. Each walk issues exactly `k+1` memory reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request, accepted when `req_ready` is 1 |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_vpn | input | 20 | Virtual page number to translate |
| asid_reg | input | 8 | Current address-space tag register |
| hat_base | input | 10 | Base address of the hash anchor table |
| ipt_base | input | 10 | Base address of the inverted table |
| max_chain | input | 9 | Maximum number of entries examined per walk |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 10 | Memory read address |
| mem_rdata | input | 37 | Read data, valid the cycle after the strobe |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Translation found |
| resp_fault | output | 1 | Page fault |
| resp_limit | output | 1 | Fault caused by the chain length limit |
| resp_frame | output | 8 | Frame number on a hit, 8'hFF on a fault |

## Verification
The assertions rely on three properties of the inputs. `max_chain`, `hat_base` and `ipt_base` stay steady while a walk is in progress. The memory returns data one cycle after each read strobe. No stored pointer other than the null code names frame 255. The stimulus changes the base and limit inputs only between walks, and the bench memory model answers with exactly one cycle of latency. Table contents place entries only in frames 0 to 254. Chains are built by prepending at the head, and one test deliberately closes a chain into a loop to reach the limit fault.

// File: rtl/ipt_pkg.sv
// Package: shared types for the inverted page table lookup engine.
// Assumes nothing beyond the walk sequence encoded here.
package ipt_pkg;

    // Walk sequencer states: idle, anchor read issued, anchor data, entry data
    typedef enum logic [1:0] {
        WALK_IDLE   = 2'd0,
        WALK_HAT    = 2'd1,
        WALK_ANCHOR = 2'd2,
        WALK_ENTRY  = 2'd3
    } walk_state_t;

endpackage

// File: rtl/ipt_hash.sv
// Module: ipt_hash
// Folds a virtual page number into an anchor-table index.
// The upper half is XORed onto the lower half, and that result is folded
// modulo HAT_W. Assumes VPN_W is even.
module ipt_hash #(
    parameter int VPN_W = 20,
    parameter int HAT_W = 8
) (
    input  logic [VPN_W-1:0] vpn,
    output logic [HAT_W-1:0] idx
);
    localparam int HALF = VPN_W / 2;

    logic [HALF-1:0] folded;

    // Purpose: combine the halves, then wrap the wide result into HAT_W bits
    always_comb begin
        folded = vpn[VPN_W-1 -: HALF] ^ vpn[HALF-1:0];
        idx    = '0;
        for (int i = 0; i < HALF; i++) begin
            idx[i % HAT_W] = idx[i % HAT_W] ^ folded[i];
        end
    end
endmodule

// File: rtl/ipt_entry_cmp.sv
// Module: ipt_entry_cmp
// Unpacks one memory word as a table entry and compares it with the request.
// Word layout: {valid, tag, page, next}. The low FRAME_W bits also serve as
// the pointer of an anchor word. A pointer of all ones is null.
module ipt_entry_cmp #(
    parameter int FRAME_W = 8,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    localparam int DATA_W = FRAME_W + VPN_W + ASID_W + 1
) (
    input  logic [DATA_W-1:0]  word,
    input  logic [VPN_W-1:0]   want_vpn,
    input  logic [ASID_W-1:0]  want_asid,
    output logic               match,
    output logic [FRAME_W-1:0] ptr,
    output logic               ptr_null
);
    logic              ent_valid;
    logic [ASID_W-1:0] ent_asid;
    logic [VPN_W-1:0]  ent_vpn;

    // Purpose: split the word into fields and form the match and null flags
    always_comb begin
        ptr       = word[FRAME_W-1:0];
        ent_vpn   = word[FRAME_W +: VPN_W];
        ent_asid  = word[FRAME_W+VPN_W +: ASID_W];
        ent_valid = word[DATA_W-1];
        ptr_null  = &ptr;
        match     = ent_valid && (ent_vpn == want_vpn) && (ent_asid == want_asid);
    end
endmodule

// File: rtl/ipt_walk_ctrl.sv
// Module: ipt_walk_ctrl
// Sequences one lookup: anchor read, then a chain of entry reads, then a
// registered one-cycle response. Assumes a memory with one cycle of read
// latency, and bases and limit that hold steady during a walk.
module ipt_walk_ctrl
    import ipt_pkg::*;
#(
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int HAT_W   = 8,
    parameter int FRAME_W = 8,
    parameter int ADDR_W  = 10,
    localparam int CHAIN_W = FRAME_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic [ASID_W-1:0]  req_asid,
    input  logic [ADDR_W-1:0]  hat_base,
    input  logic [ADDR_W-1:0]  ipt_base,
    input  logic [CHAIN_W-1:0] max_chain,
    output logic [VPN_W-1:0]   vpn_q,
    output logic [ASID_W-1:0]  asid_q,
    input  logic [HAT_W-1:0]   hash_idx,
    input  logic               word_match,
    input  logic [FRAME_W-1:0] word_ptr,
    input  logic               word_null,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               resp_valid,
    output logic               resp_hit,
    output logic               resp_fault,
    output logic               resp_limit,
    output logic [FRAME_W-1:0] resp_frame
);
    localparam logic [FRAME_W-1:0] NULL_PTR = '1;

    walk_state_t        state;
    logic [FRAME_W-1:0] cur_ptr;
    logic [CHAIN_W-1:0] walk_cnt;
    logic [CHAIN_W-1:0] limit_eff;
    logic               at_limit;

    // Purpose: treat a zero limit as one entry
    always_comb begin
        limit_eff = (max_chain == '0) ? CHAIN_W'(1) : max_chain;
        at_limit  = (walk_cnt >= limit_eff);
    end

    assign req_ready = (state == WALK_IDLE);

    // Purpose: choose the memory read issued in the current state
    always_comb begin
        mem_rd_en = 1'b0;
        mem_addr  = '0;
        case (state)
            WALK_HAT: begin
                mem_rd_en = 1'b1;
                mem_addr  = hat_base + ADDR_W'(hash_idx);
            end
            WALK_ANCHOR: begin
                if (!word_null) begin
                    mem_rd_en = 1'b1;
                    mem_addr  = ipt_base + ADDR_W'(word_ptr);
                end
            end
            WALK_ENTRY: begin
                if (!word_match && !word_null && !at_limit) begin
                    mem_rd_en = 1'b1;
                    mem_addr  = ipt_base + ADDR_W'(word_ptr);
                end
            end
            default: ;
        endcase
    end

    // Purpose: advance the walk and register the response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= WALK_IDLE;
            vpn_q      <= '0;
            asid_q     <= '0;
            cur_ptr    <= '0;
            walk_cnt   <= '0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_fault <= 1'b0;
            resp_limit <= 1'b0;
            resp_frame <= NULL_PTR;
        end else begin
            resp_valid <= 1'b0;
            case (state)
                WALK_IDLE: begin
                    if (req_valid) begin
                        vpn_q  <= req_vpn;
                        asid_q <= req_asid;
                        state  <= WALK_HAT;
                    end
                end
                WALK_HAT: begin
                    state <= WALK_ANCHOR;
                end
                WALK_ANCHOR: begin
                    if (word_null) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b0;
                        resp_fault <= 1'b1;
                        resp_limit <= 1'b0;
                        resp_frame <= NULL_PTR;
                        state      <= WALK_IDLE;
                    end else begin
                        cur_ptr  <= word_ptr;
                        walk_cnt <= CHAIN_W'(1);
                        state    <= WALK_ENTRY;
                    end
                end
                WALK_ENTRY: begin
                    if (word_match) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b1;
                        resp_fault <= 1'b0;
                        resp_limit <= 1'b0;
                        resp_frame <= cur_ptr;
                        state      <= WALK_IDLE;
                    end else if (word_null || at_limit) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b0;
                        resp_fault <= 1'b1;
                        resp_limit <= !word_null;
                        resp_frame <= NULL_PTR;
                        state      <= WALK_IDLE;
                    end else begin
                        cur_ptr  <= word_ptr;
                        walk_cnt <= walk_cnt + CHAIN_W'(1);
                    end
                end
                default: state <= WALK_IDLE;
            endcase
        end
    end

    // R11
    resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_hit ^ resp_fault));

    // R9
    limit_is_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_limit) |-> (resp_fault && !resp_hit));

    // R9
    walk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WALK_ENTRY) |-> (walk_cnt >= CHAIN_W'(1) && walk_cnt <= limit_eff));

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

    // R4
    hit_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> (resp_frame != NULL_PTR));

    // R10
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
endmodule

// File: rtl/ipt_lookup_engine.sv
// Module: ipt_lookup_engine (top)
// Translates a page number plus an address-space tag into a frame number by
// walking a hash-anchored chain in an inverted table. Assumes the anchor table
// and the inverted table share one synchronous memory with 1-cycle read latency.
module ipt_lookup_engine #(
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int HAT_W   = 8,
    parameter int FRAME_W = 8,
    parameter int ADDR_W  = 10,
    localparam int DATA_W  = FRAME_W + VPN_W + ASID_W + 1,
    localparam int CHAIN_W = FRAME_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic [ASID_W-1:0]  asid_reg,
    input  logic [ADDR_W-1:0]  hat_base,
    input  logic [ADDR_W-1:0]  ipt_base,
    input  logic [CHAIN_W-1:0] max_chain,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               resp_valid,
    output logic               resp_hit,
    output logic               resp_fault,
    output logic               resp_limit,
    output logic [FRAME_W-1:0] resp_frame
);
    logic [VPN_W-1:0]   vpn_q;
    logic [ASID_W-1:0]  asid_q;
    logic [HAT_W-1:0]   hash_idx;
    logic               word_match;
    logic [FRAME_W-1:0] word_ptr;
    logic               word_null;

    ipt_hash #(.VPN_W(VPN_W), .HAT_W(HAT_W)) u_hash (
        .vpn (vpn_q),
        .idx (hash_idx)
    );

    ipt_entry_cmp #(.FRAME_W(FRAME_W), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cmp (
        .word      (mem_rdata),
        .want_vpn  (vpn_q),
        .want_asid (asid_q),
        .match     (word_match),
        .ptr       (word_ptr),
        .ptr_null  (word_null)
    );

    ipt_walk_ctrl #(
        .VPN_W(VPN_W), .ASID_W(ASID_W), .HAT_W(HAT_W),
        .FRAME_W(FRAME_W), .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vpn    (req_vpn),
        .req_asid   (asid_reg),
        .hat_base   (hat_base),
        .ipt_base   (ipt_base),
        .max_chain  (max_chain),
        .vpn_q      (vpn_q),
        .asid_q     (asid_q),
        .hash_idx   (hash_idx),
        .word_match (word_match),
        .word_ptr   (word_ptr),
        .word_null  (word_null),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .resp_valid (resp_valid),
        .resp_hit   (resp_hit),
        .resp_fault (resp_fault),
        .resp_limit (resp_limit),
        .resp_frame (resp_frame)
    );
endmodule

// File: tb/sim_ipt_lookup_engine.sv
// Bench for ipt_lookup_engine: directed chain cases plus seeded random tables.
module sim_ipt_lookup_engine;
    localparam int HAT_BASE = 768;
    localparam int IPT_BASE = 0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_vpn = '0;
    logic [7:0]  asid_reg = '0;
    logic [9:0]  hat_base = 10'(HAT_BASE);
    logic [9:0]  ipt_base = 10'(IPT_BASE);
    logic [8:0]  max_chain = 9'd255;
    logic        mem_rd_en;
    logic [9:0]  mem_addr;
    logic [36:0] mem_rdata = '0;
    logic        resp_valid, resp_hit, resp_fault, resp_limit;
    logic [7:0]  resp_frame;

    logic [36:0] mem [0:1023];
    logic [9:0]  rd_log [0:63];
    int          rd_total = 0;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    ipt_lookup_engine u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .asid_reg(asid_reg), .hat_base(hat_base), .ipt_base(ipt_base),
        .max_chain(max_chain), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_fault(resp_fault), .resp_limit(resp_limit), .resp_frame(resp_frame)
    );

    // memory model with one cycle of read latency, plus a read log
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            rd_log[rd_total % 64] <= mem_addr;
            rd_total <= rd_total + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] href(logic [19:0] v);
        logic [9:0] x;
        x = v[19:10] ^ v[9:0];
        return x[7:0] ^ {6'b0, x[9:8]};
    endfunction

    task automatic clear_tables();
        for (int i = 0; i < 256; i++) begin
            mem[HAT_BASE + i] = '1;
            mem[IPT_BASE + i] = {1'b0, 8'h0, 20'h0, 8'hFF};
        end
    endtask

    // prepend a mapping at the head of its chain
    task automatic insert(int frame, logic [19:0] v, logic [7:0] a);
        logic [7:0] h;
        h = href(v);
        mem[IPT_BASE + frame] = {1'b1, a, v, mem[HAT_BASE + h][7:0]};
        mem[HAT_BASE + h] = {29'h0, 8'(frame)};
    endtask

    // reference walk computed from the requirements
    task automatic ref_walk(logic [19:0] v, logic [7:0] a, int maxc,
                            output bit hit, output bit lim, output logic [7:0] frame,
                            output int k);
        logic [7:0]  p;
        logic [36:0] e;
        int          cap;
        cap = (maxc == 0) ? 1 : maxc;
        p = mem[HAT_BASE + href(v)][7:0];
        k = 0; hit = 0; lim = 0; frame = 8'hFF;
        while (p != 8'hFF) begin
            e = mem[IPT_BASE + p];
            k = k + 1;
            if (e[36] && e[27:8] == v && e[35:28] == a) begin
                hit = 1; frame = p; break;
            end
            if (e[7:0] == 8'hFF) break;
            if (k >= cap) begin lim = 1; break; end
            p = e[7:0];
        end
    endtask

    task automatic lookup(logic [19:0] v, logic [7:0] a, int maxc, string rq);
        bit         e_hit, e_lim;
        logic [7:0] e_frame;
        int         k, n, start;
        ref_walk(v, a, maxc, e_hit, e_lim, e_frame, k);
        @(negedge clk);
        start = rd_total;
        req_vpn = v; asid_reg = a; max_chain = 9'(maxc); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        chk("R10", "ready low while walking", 32'(req_ready), 32'd0);
        while (!resp_valid && n < 400) begin
            @(negedge clk);
            n = n + 1;
        end
        chk(rq, "hit", 32'(resp_hit), 32'(e_hit));
        chk(rq, "fault", 32'(resp_fault), 32'(!e_hit));
        chk(rq, "limit", 32'(resp_limit), 32'(e_lim));
        chk(rq, "frame", 32'(resp_frame), 32'(e_frame));
        chk("R10", "latency", 32'(n), 32'(k + 3));
        chk("R2", "anchor address", 32'(rd_log[start % 64]), 32'(HAT_BASE + href(v)));
        chk("R11", "read count", 32'(rd_total - start), 32'(k + 1));
        @(negedge clk);
        chk("R10", "single pulse", 32'(resp_valid), 32'd0);
    endtask

    initial begin
        logic [19:0] va, vb, vc, vd;
        bit          used [0:255];
        logic [19:0] keys [0:59];
        logic [7:0]  tags [0:59];
        void'($urandom(32'd20240611));
        clear_tables();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "ready", 32'(req_ready), 32'd1);
        chk("R1", "resp_valid", 32'(resp_valid), 32'd0);
        chk("R1", "mem_rd_en", 32'(mem_rd_en), 32'd0);
        rst_n = 1'b1;

        // R3: empty anchor
        lookup(20'h12345, 8'd1, 255, "R3");

        // R4: single entry hit
        va = 20'h2A5C3;
        insert(5, va, 8'd1);
        lookup(va, 8'd1, 255, "R4");
        chk("R4", "frame is index", 32'(resp_frame), 32'd5);

        // R5/R6/R8: three colliding pages, chain 30 -> 20 -> 10
        clear_tables();
        vb = va ^ 20'h00401;
        vc = va ^ 20'h00802;
        vd = va ^ 20'h00C03;
        insert(10, va, 8'd1);
        insert(20, vb, 8'd1);
        insert(30, vc, 8'd1);
        lookup(va, 8'd1, 255, "R5");
        lookup(va, 8'd2, 255, "R6");
        lookup(vd, 8'd1, 255, "R8");

        // R5: duplicate at the head wins
        insert(40, va, 8'd1);
        lookup(va, 8'd1, 255, "R5");
        chk("R5", "first match frame", 32'(resp_frame), 32'd40);

        // R7: invalid head is skipped
        mem[IPT_BASE + 40][36] = 1'b0;
        lookup(va, 8'd1, 255, "R7");
        chk("R7", "skipped to frame", 32'(resp_frame), 32'd10);

        // R9: limit below, at, and zero
        lookup(va, 8'd1, 3, "R9");
        chk("R9", "limit flag", 32'(resp_limit), 32'd1);
        lookup(va, 8'd1, 4, "R9");
        chk("R9", "hit at limit", 32'(resp_hit), 32'd1);
        lookup(vc, 8'd1, 0, "R9");

        // R9: cyclic chain 40 -> 30 -> 20 -> 10 -> 40
        mem[IPT_BASE + 10][7:0] = 8'd40;
        lookup(vd, 8'd1, 20, "R9");
        chk("R9", "cycle stopped", 32'(resp_limit), 32'd1);

        // random tables
        for (int round = 0; round < 3; round++) begin
            clear_tables();
            for (int i = 0; i < 256; i++) used[i] = 1'b0;
            for (int i = 0; i < 60; i++) begin
                int f;
                f = int'($urandom % 255);
                while (used[f]) f = (f + 1) % 255;
                used[f] = 1'b1;
                keys[i] = 20'($urandom);
                if (i % 4 == 0) keys[i] = keys[i / 2] ^ 20'h00401;
                tags[i] = 8'($urandom % 4);
                insert(f, keys[i], tags[i]);
            end
            for (int j = 0; j < 60; j++) begin
                int sel;
                sel = int'($urandom % 60);
                case ($urandom % 3)
                    0: lookup(keys[sel], tags[sel], 255, "R4");
                    1: lookup(keys[sel], 8'($urandom % 4), int'($urandom % 4), "R9");
                    default: lookup(20'($urandom), tags[sel], 255, "R8");
                endcase
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule